// File: doc/BRIEF.md
# Bus-Idle Watchdog with Selectable Timeout

This block watches a serial bus for signs of life and pulls a reset line when the bus stays quiet for too long. Each bus transaction shows up as a one-cycle `bus_act` pulse, for example taken from a synchronized chip-select falling edge. The idle time is measured in `tick` pulses from a shared time base.

A 2-bit code picks one of three idle limits or turns the watchdog off. When the limit runs out, the block drives a reset pulse of fixed length on a pair of complementary outputs. After the pulse it starts timing again from zero. A digital low-supply input also forces reset for as long as it is high, and it holds the idle count at zero.

Control is a three-state machine:
- `ST_WATCH` counts ticks.
- `ST_FIRE` drives the reset pulse.
- `ST_OFF` is the disabled state.

Its transitions are:
- WATCH→FIRE (expiry).
- FIRE→WATCH (pulse end with an enabled code).
- FIRE→OFF (pulse end with code 11).
- WATCH→OFF (code 11 selected).
- OFF→WATCH (an enabled code selected).

Top module: `bus_watchdog`

## Requirements
- R1: In the watching state, reset rises exactly on the clock edge that takes in the N-th tick with no bus activity, counted from the last restart. N is TICKS_LONG (14) for code 00, TICKS_MID (6) for code 01 and TICKS_SHORT (2) for code 10.
- R2: After reset is released by `rst_n`, `wd_rst` is 0 and `wd_rst_n` is 1.
- R3: A `bus_act` pulse while watching clears the idle count. A full N further ticks are then needed to fire.
- R4: A `bus_act` pulse in the same cycle as the tick that would have expired the count wins. No reset is produced, and the count restarts from zero.
- R5: A timeout reset pulse lasts exactly PULSE_LEN (4) clock cycles. After it ends, a full N ticks are again needed to fire.
- R6: `wd_rst_n` is always the complement of `wd_rst`.
- R7: With code 11 the watchdog is disabled. No number of ticks produces a reset, and re-enabling starts the count from zero.
- R8: Any change of `wd_sel` while watching restarts the count. The new code's N is then needed.
- R9: `low_supply` high drives `wd_rst` high in the same cycle, without waiting for a clock edge. While it is high the idle count is held at zero.
- R10: Ticks and `bus_act` during a reset pulse are ignored. They neither lengthen the pulse nor advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_act | input | 1 | One-cycle pulse per bus transaction |
| tick | input | 1 | One-cycle time-base pulse |
| wd_sel | input | 2 | Timeout code: 00 long, 01 mid, 10 short, 11 off |
| low_supply | input | 1 | Supply-below-threshold flag |
| wd_rst | output | 1 | Active-high reset out |
| wd_rst_n | output | 1 | Active-low reset out |

## Verification
Bus activity and the expiring tick can fall in the same cycle. The bench provokes this by sending N-1 ticks and then driving `tick` and `bus_act` together. It judges the result by requiring no reset in that cycle, and then exactly N more ticks before the next reset. Low supply can also coincide with an almost-expired count. That case is judged by checking that `wd_rst` follows the supply flag at once and that, after release, the full N ticks are needed again.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_FIRE  = 2'd1,
        ST_OFF   = 2'd2
    } wd_state_t;

    localparam logic [1:0] SEL_LONG  = 2'b00;
    localparam logic [1:0] SEL_MID   = 2'b01;
    localparam logic [1:0] SEL_SHORT = 2'b10;
    localparam logic [1:0] SEL_OFF   = 2'b11;
endpackage

// File: rtl/wd_limit_sel.sv
module wd_limit_sel #(
    parameter int TICKS_LONG  = 14,
    parameter int TICKS_MID   = 6,
    parameter int TICKS_SHORT = 2,
    parameter int CNT_W       = 4
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] last_cnt,
    output logic             enabled
);
    import wdog_pkg::*;

    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(TICKS_LONG - 1);
    localparam logic [CNT_W-1:0] LAST_MID   = CNT_W'(TICKS_MID - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(TICKS_SHORT - 1);

    always_comb begin
        enabled  = 1'b1;
        last_cnt = LAST_LONG;
        unique case (sel)
            SEL_LONG:  last_cnt = LAST_LONG;
            SEL_MID:   last_cnt = LAST_MID;
            SEL_SHORT: last_cnt = LAST_SHORT;
            SEL_OFF: begin
                last_cnt = '0;
                enabled  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wd_tick_cnt.sv
module wd_tick_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/wd_pulse_cnt.sv
module wd_pulse_cnt #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int PW = (PULSE_LEN < 2) ? 1 : $clog2(PULSE_LEN);
    localparam logic [PW-1:0] LAST = PW'(PULSE_LEN - 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog #(
    parameter int TICKS_LONG  = 14,
    parameter int TICKS_MID   = 6,
    parameter int TICKS_SHORT = 2,
    parameter int PULSE_LEN   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_act,
    input  logic       tick,
    input  logic [1:0] wd_sel,
    input  logic       low_supply,
    output logic       wd_rst,
    output logic       wd_rst_n
);
    import wdog_pkg::*;

    localparam int MAX_A = (TICKS_LONG > TICKS_MID) ? TICKS_LONG : TICKS_MID;
    localparam int MAX_T = (MAX_A > TICKS_SHORT) ? MAX_A : TICKS_SHORT;
    localparam int CNT_W = $clog2(MAX_T + 1);

    wd_state_t        state_q, state_d;
    logic [1:0]       sel_q;
    logic             sel_chg;
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] last_cnt;
    logic             enabled;
    logic             pulse_done;
    logic             expire;
    logic             cnt_clr;
    logic             firing;

    wd_limit_sel #(
        .TICKS_LONG (TICKS_LONG),
        .TICKS_MID  (TICKS_MID),
        .TICKS_SHORT(TICKS_SHORT),
        .CNT_W      (CNT_W)
    ) u_limit (
        .sel     (wd_sel),
        .last_cnt(last_cnt),
        .enabled (enabled)
    );

    assign sel_chg = (wd_sel != sel_q);
    assign firing  = (state_q == ST_FIRE);

    // Expiry: last tick lands with no restart cause in the same cycle.
    assign expire = (state_q == ST_WATCH) && enabled && tick && !bus_act
                    && !sel_chg && !low_supply && (elapsed == last_cnt);

    assign cnt_clr = (state_q != ST_WATCH) || !enabled || bus_act
                     || sel_chg || low_supply || expire;

    wd_tick_cnt #(
        .CNT_W(CNT_W)
    ) u_ticks (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (tick),
        .count(elapsed)
    );

    wd_pulse_cnt #(
        .PULSE_LEN(PULSE_LEN)
    ) u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (firing),
        .done (pulse_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WATCH;
            sel_q   <= SEL_LONG;
        end else begin
            state_q <= state_d;
            sel_q   <= wd_sel;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH: begin
                if (!enabled)    state_d = ST_OFF;
                else if (expire) state_d = ST_FIRE;
            end
            ST_FIRE: begin
                if (pulse_done) state_d = enabled ? ST_WATCH : ST_OFF;
            end
            ST_OFF: begin
                if (enabled) state_d = ST_WATCH;
            end
            default: state_d = ST_WATCH;
        endcase
    end

    // Outputs
    always_comb begin
        wd_rst   = firing || low_supply;
        wd_rst_n = !(firing || low_supply);
    end
endmodule

// File: rtl/wd_checker.sv
module wd_checker #(
    parameter int PULSE_LEN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_act,
    input logic       tick,
    input logic [1:0] wd_sel,
    input logic       low_supply,
    input logic       wd_rst,
    input logic       wd_rst_n,
    input logic       firing
);
    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_len <= 0;
        else        run_len <= firing ? run_len + 1 : 0;
    end

    // R6
    out_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_n != wd_rst);

    // R9
    low_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_supply |-> wd_rst);

    // R3
    act_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_act && !wd_rst) |=> (!wd_rst || low_supply));

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_sel == 2'b11 && !wd_rst) |=> (!wd_rst || low_supply));

    // R1
    fire_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(firing) |-> $past(tick));

    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(firing) |-> (run_len == PULSE_LEN));

    // R10
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        firing |-> (run_len < PULSE_LEN));
endmodule

bind bus_watchdog wd_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_act   (bus_act),
    .tick      (tick),
    .wd_sel    (wd_sel),
    .low_supply(low_supply),
    .wd_rst    (wd_rst),
    .wd_rst_n  (wd_rst_n),
    .firing    (firing)
);

// File: tb/tb_bus_watchdog.sv
module tb_bus_watchdog;
    localparam int PULSE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_act = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] wd_sel = 2'b00;
    logic       low_supply = 1'b0;
    logic       wd_rst;
    logic       wd_rst_n;

    int  total = 0;
    int  bad = 0;
    bit  ended = 1'b0;

    always #10 clk = ~clk;

    bus_watchdog dut (
        .clk(clk), .rst_n(rst_n), .bus_act(bus_act), .tick(tick),
        .wd_sel(wd_sel), .low_supply(low_supply),
        .wd_rst(wd_rst), .wd_rst_n(wd_rst_n)
    );

    function automatic int limit_of(input int code);
        return (code == 0) ? 14 : (code == 1) ? 6 : 2;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive for one cycle, sample after the edge that took it in
    task automatic step(input bit t, input bit a);
        @(negedge clk);
        tick = t; bus_act = a;
        @(negedge clk);
        tick = 0; bus_act = 0;
    endtask

    task automatic pulse_width(output int n);
        n = 0;
        while (wd_rst === 1'b1 && n < 50) begin
            chk(wd_rst_n === 1'b0, "R6 pulse complement", int'(wd_rst_n), 0);
            n++;
            @(negedge clk);
        end
    endtask

    // ticks 1..n must stay quiet, except the last one when fire_last is set
    task automatic run_ticks(input int n, input bit fire_last, input string req);
        for (int i = 1; i <= n; i++) begin
            step(1'b1, 1'b0);
            chk(wd_rst === (fire_last && i == n), req, int'(wd_rst),
                int'(fire_last && i == n));
        end
    endtask

    initial begin
        int w;
        repeat (3) @(negedge clk);
        chk(wd_rst === 1'b0 && wd_rst_n === 1'b1, "R2 in reset", int'(wd_rst), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wd_rst === 1'b0 && wd_rst_n === 1'b1, "R2 after reset", int'(wd_rst), 0);

        // R1 / R5 sweep over every enabled code
        for (int s = 0; s < 3; s++) begin
            int L;
            L = limit_of(s);
            wd_sel = 2'(s);
            step(1'b0, 1'b1);
            run_ticks(L, 1'b1, "R1 expiry tick");
            pulse_width(w);
            chk(w == PULSE, "R5 pulse length", w, PULSE);
            chk(wd_rst_n === 1'b1, "R6 after pulse", int'(wd_rst_n), 1);
            run_ticks(L, 1'b1, "R5 full count after pulse");
            pulse_width(w);
            chk(w == PULSE, "R5 second pulse length", w, PULSE);
        end

        // R3: activity restarts the count
        for (int s = 0; s < 3; s++) begin
            int L;
            L = limit_of(s);
            wd_sel = 2'(s);
            step(1'b0, 1'b1);
            run_ticks(L - 1, 1'b0, "R3 before activity");
            step(1'b0, 1'b1);
            chk(wd_rst === 1'b0, "R3 activity", int'(wd_rst), 0);
            run_ticks(L, 1'b1, "R3 full count after activity");
            pulse_width(w);
        end

        // R4: activity coinciding with the expiring tick wins
        for (int s = 0; s < 3; s++) begin
            int L;
            L = limit_of(s);
            wd_sel = 2'(s);
            step(1'b0, 1'b1);
            run_ticks(L - 1, 1'b0, "R4 approach");
            step(1'b1, 1'b1);
            chk(wd_rst === 1'b0, "R4 coincident tick and activity", int'(wd_rst), 0);
            run_ticks(L, 1'b1, "R4 restarted count");
            pulse_width(w);
        end

        // R10: ticks and activity during the pulse are ignored
        wd_sel = 2'b10;
        step(1'b0, 1'b1);
        run_ticks(2, 1'b1, "R10 fire");
        step(1'b1, 1'b0);
        chk(wd_rst === 1'b1, "R10 tick in pulse", int'(wd_rst), 1);
        step(1'b1, 1'b1);
        chk(wd_rst === 1'b0, "R10 pulse not lengthened", int'(wd_rst), 0);
        run_ticks(2, 1'b1, "R10 count not advanced");
        pulse_width(w);

        // R7: disabled code never fires; re-enable counts from zero
        wd_sel = 2'b11;
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b0);
            if (wd_rst !== 1'b0)
                chk(1'b0, "R7 disabled", int'(wd_rst), 0);
        end
        chk(wd_rst === 1'b0, "R7 disabled after 40 ticks", int'(wd_rst), 0);
        wd_sel = 2'b10;
        step(1'b0, 1'b0);
        run_ticks(2, 1'b1, "R7 re-enable counts from zero");
        pulse_width(w);

        // R8: a code change restarts the count
        wd_sel = 2'b00;
        step(1'b0, 1'b1);
        run_ticks(5, 1'b0, "R8 long partial");
        wd_sel = 2'b01;
        run_ticks(6, 1'b1, "R8 new code full count");
        pulse_width(w);

        // R9: low supply asserts at once and holds the count at zero
        wd_sel = 2'b10;
        step(1'b0, 1'b1);
        run_ticks(1, 1'b0, "R9 approach");
        @(negedge clk);
        low_supply = 1'b1;
        #2;
        chk(wd_rst === 1'b1 && wd_rst_n === 1'b0, "R9 immediate", int'(wd_rst), 1);
        step(1'b1, 1'b0);
        chk(wd_rst === 1'b1, "R9 held", int'(wd_rst), 1);
        low_supply = 1'b0;
        #2;
        chk(wd_rst === 1'b0, "R9 release", int'(wd_rst), 0);
        run_ticks(2, 1'b1, "R9 count held at zero");
        pulse_width(w);

        // R9 during a pulse keeps reset high beyond the pulse
        run_ticks(2, 1'b1, "R9 fire");
        low_supply = 1'b1;
        repeat (PULSE + 2) @(negedge clk);
        chk(wd_rst === 1'b1, "R9 overrides pulse end", int'(wd_rst), 1);
        low_supply = 1'b0;
        #2;
        chk(wd_rst === 1'b0, "R9 release after pulse", int'(wd_rst), 0);

        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule